// File: doc/BRIEF.md
# Graceful Overcurrent Protection Controller

This block guards a multi-channel PWM power stage against high-current events. Each channel supplies an overcurrent pulse that is high while the sensed current is above a fixed threshold. The block answers along a ladder of rising severity. The first rung cuts the drive level. The second clips each PWM pulse cycle by cycle. The third attenuates the output signal. The last rung shuts the output stage down. How far the block climbs depends on how many frames in a row contain an event. It also tells a short circuit apart from an ordinary overcurrent: a short circuit is a single, unbroken assertion that is too long.

The block runs in the PWM clock domain. A one-cycle frame strobe marks each PWM frame boundary. Firmware sets the thresholds through configuration inputs, reads the level and the two fault flags, and releases a shutdown with a one-cycle clear pulse. After enough quiet frames the ladder steps back down one rung at a time. Shutdown is the exception: it holds until the clear pulse arrives.

Top module: `ocp_guard`

## Requirements
- R1: Each overcurrent input passes through two synchronizing flops. If `oc_raw` rises while the block is idle, `drive_cut` stays low after the first and second rising edges and goes high after the third.
- R2: While `level_o` is 0 (idle), any synchronized overcurrent raises the level to 1 (drive cut) on the next edge, without waiting for a frame strobe. `drive_cut` is high whenever `level_o` is not 0.
- R3: A frame is a hit frame if an overcurrent was seen at any time in it. On each strobe, a hit frame increments a consecutive-event counter, which saturates. The level is then raised to 2 (clip) when the counter is at least `thr_clip`, to 3 (attenuate) when it is at least `thr_atten`, and to 4 (off) when it is at least `thr_off`. The level never falls at that point.
- R4: At level 2 or above, a channel whose synchronized overcurrent is high has its `pwm_out` bit forced low. The bit stays low for the rest of that frame and is released at the next strobe. Other channels are not affected. `pwm_out` is never high where `pwm_in` is low.
- R5: `atten_on` is high exactly when the level is 3 or 4.
- R6: At level 4, `stage_en` is low and all of `pwm_out` is low. Level 4 is held through any number of quiet frames until `fw_clear`.
- R7: On each strobe, a frame with no event decrements the counter, stopping at 0, and adds one to a quiet-frame count. Any hit frame resets the quiet-frame count. When the count reaches `quiet_frames`, the level drops by one (but not from level 4) and the count restarts. The level never falls by more than one per cycle unless a clear occurs.
- R8: A short circuit is declared when the combined synchronized overcurrent stays high for more than `sc_limit` consecutive cycles inside one frame. A strobe or a low cycle restarts the run. A short circuit moves the level directly to 4.
- R9: `short_flag` is set when level 4 is entered through a short circuit. `oc_flag` is set when level 4 is entered through the frame counter. The two flags are never high together.
- R10: `fw_clear` returns the level, the counters, the frame-hit memory and both flags to 0 on the next edge. It takes priority over a frame strobe in the same cycle, so that frame's hit is not counted.
- R11: After reset the level is 0, `stage_en` is high, both flags and `drive_cut` are low, and `pwm_out` equals `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle pulse at each PWM frame boundary |
| fw_clear | input | 1 | One-cycle firmware clear of level, counters and flags |
| oc_raw | input | NCH | Asynchronous overcurrent pulses, one per channel |
| pwm_in | input | NCH | PWM pulses from the modulator |
| thr_clip | input | CNT_W | Hit-frame count that enables clipping |
| thr_atten | input | CNT_W | Hit-frame count that enables attenuation |
| thr_off | input | CNT_W | Hit-frame count that shuts the stage off |
| quiet_frames | input | CNT_W | Quiet frames needed per de-escalation step |
| sc_limit | input | RUN_W | Longest unbroken overcurrent run, in cycles, that is tolerated |
| pwm_out | output | NCH | Gated PWM pulses to the power stage |
| drive_cut | output | 1 | Request to reduce drive level |
| atten_on | output | 1 | Request to attenuate the output signal |
| stage_en | output | 1 | Output stage enable |
| level_o | output | 3 | Current protection level, 0 to 4 |
| short_flag | output | 1 | Shutdown was caused by a short circuit |
| oc_flag | output | 1 | Shutdown was caused by persistent overcurrent |

## Verification
Two things can happen in the same cycle: a firmware clear and a frame strobe that closes a hit frame. If the strobe won, the old hit would reach the counter. If the clear won, the counter starts fresh. The bench ends a hit frame by raising `fw_clear` and `frame_strobe` together. It then runs two more hit frames. Clipping must first appear after the second of these frames, not after the first. A second overlap is between a clip mark and the strobe that must release it. The bench checks that `pwm_out` recovers on the first sample after the strobe while the level has already climbed.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        LV_IDLE  = 3'd0,
        LV_CUT   = 3'd1,
        LV_CLIP  = 3'd2,
        LV_ATTEN = 3'd3,
        LV_OFF   = 3'd4
    } ocp_lvl_e;

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= async_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/ocp_clip.sv
module ocp_clip #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe_i,
    input  logic           clear_i,
    input  logic           clip_en_i,
    input  logic           off_i,
    input  logic [NCH-1:0] oc_i,
    input  logic [NCH-1:0] pwm_i,
    output logic [NCH-1:0] pwm_o
);
    logic [NCH-1:0] mark_d, mark_q;
    logic [NCH-1:0] trip;

    always_comb begin
        trip   = oc_i & {NCH{clip_en_i}};
        mark_d = (strobe_i || clear_i) ? '0 : (mark_q | trip);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mark_q <= '0;
        else        mark_q <= mark_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_gate
        assign pwm_o[g] = pwm_i[g] & ~mark_q[g] & ~trip[g] & ~off_i;
    end
endmodule

// File: rtl/ocp_runlen.sv
module ocp_runlen #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oc_any_i,
    input  logic             strobe_i,
    input  logic             clear_i,
    input  logic [RUN_W-1:0] limit_i,
    output logic             short_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_d, run_q;
    logic [RUN_W:0]   run_next;

    always_comb begin
        run_next = {1'b0, run_q} + 1'b1;
        if (strobe_i || clear_i || !oc_any_i) run_d = '0;
        else if (run_q == RUN_MAX)            run_d = run_q;
        else                                  run_d = run_next[RUN_W-1:0];
        short_o = oc_any_i && !strobe_i && !clear_i && (run_next > {1'b0, limit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/ocp_ladder.sv
module ocp_ladder
    import ocp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oc_any_i,
    input  logic             strobe_i,
    input  logic             clear_i,
    input  logic             short_i,
    input  logic [CNT_W-1:0] thr_clip_i,
    input  logic [CNT_W-1:0] thr_atten_i,
    input  logic [CNT_W-1:0] thr_off_i,
    input  logic [CNT_W-1:0] quiet_i,
    output ocp_lvl_e         lvl_o,
    output logic             short_flag_o,
    output logic             oc_flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        ocp_lvl_e         lvl;
        logic [CNT_W-1:0] ev;
        logic [CNT_W-1:0] quiet;
        logic             hit;
        logic             sc_f;
        logic             oc_f;
    } ladder_t;

    ladder_t st_d, st_q;
    ocp_lvl_e tgt;
    logic [CNT_W-1:0] ev_up;
    logic [CNT_W-1:0] quiet_up;
    logic had;

    always_comb begin
        st_d     = st_q;
        had      = st_q.hit || oc_any_i;
        ev_up    = (st_q.ev == CNT_MAX) ? st_q.ev : st_q.ev + 1'b1;
        quiet_up = (st_q.quiet == CNT_MAX) ? st_q.quiet : st_q.quiet + 1'b1;
        if (ev_up >= thr_off_i)        tgt = LV_OFF;
        else if (ev_up >= thr_atten_i) tgt = LV_ATTEN;
        else if (ev_up >= thr_clip_i)  tgt = LV_CLIP;
        else                           tgt = LV_IDLE;

        if (clear_i) begin
            st_d = '0;
        end else begin
            if (oc_any_i) st_d.hit = 1'b1;
            if (st_q.lvl == LV_IDLE && oc_any_i) st_d.lvl = LV_CUT;
            if (strobe_i) begin
                st_d.hit = 1'b0;
                if (had) begin
                    st_d.ev    = ev_up;
                    st_d.quiet = '0;
                    if (st_q.lvl != LV_OFF && tgt > st_d.lvl) begin
                        st_d.lvl = tgt;
                        if (tgt == LV_OFF) st_d.oc_f = 1'b1;
                    end
                end else begin
                    st_d.ev = (st_q.ev == '0) ? st_q.ev : st_q.ev - 1'b1;
                    if (st_q.lvl != LV_OFF) begin
                        if (quiet_up >= quiet_i) begin
                            st_d.quiet = '0;
                            if (st_q.lvl != LV_IDLE)
                                st_d.lvl = ocp_lvl_e'(st_q.lvl - 3'd1);
                        end else begin
                            st_d.quiet = quiet_up;
                        end
                    end
                end
            end
            if (short_i && st_q.lvl != LV_OFF && st_d.lvl != LV_OFF) begin
                st_d.lvl  = LV_OFF;
                st_d.sc_f = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o        = st_q.lvl;
    assign short_flag_o = st_q.sc_f;
    assign oc_flag_o    = st_q.oc_f;
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
    import ocp_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 4,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             fw_clear,
    input  logic [NCH-1:0]   oc_raw,
    input  logic [NCH-1:0]   pwm_in,
    input  logic [CNT_W-1:0] thr_clip,
    input  logic [CNT_W-1:0] thr_atten,
    input  logic [CNT_W-1:0] thr_off,
    input  logic [CNT_W-1:0] quiet_frames,
    input  logic [RUN_W-1:0] sc_limit,
    output logic [NCH-1:0]   pwm_out,
    output logic             drive_cut,
    output logic             atten_on,
    output logic             stage_en,
    output logic [2:0]       level_o,
    output logic             short_flag,
    output logic             oc_flag
);
    logic [NCH-1:0] oc_s;
    logic           oc_any;
    logic           sc_det;
    ocp_lvl_e       lvl;

    assign oc_any = |oc_s;

    ocp_sync #(.W(NCH)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(oc_raw), .sync_o(oc_s)
    );

    ocp_runlen #(.RUN_W(RUN_W)) run_i (
        .clk(clk), .rst_n(rst_n), .oc_any_i(oc_any), .strobe_i(frame_strobe),
        .clear_i(fw_clear), .limit_i(sc_limit), .short_o(sc_det)
    );

    ocp_ladder #(.CNT_W(CNT_W)) ladder_i (
        .clk(clk), .rst_n(rst_n), .oc_any_i(oc_any), .strobe_i(frame_strobe),
        .clear_i(fw_clear), .short_i(sc_det), .thr_clip_i(thr_clip),
        .thr_atten_i(thr_atten), .thr_off_i(thr_off), .quiet_i(quiet_frames),
        .lvl_o(lvl), .short_flag_o(short_flag), .oc_flag_o(oc_flag)
    );

    ocp_clip #(.NCH(NCH)) clip_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(frame_strobe), .clear_i(fw_clear),
        .clip_en_i(lvl >= LV_CLIP), .off_i(lvl == LV_OFF), .oc_i(oc_s),
        .pwm_i(pwm_in), .pwm_o(pwm_out)
    );

    assign level_o   = lvl;
    assign drive_cut = (lvl != LV_IDLE);
    assign atten_on  = (lvl == LV_ATTEN) || (lvl == LV_OFF);
    assign stage_en  = (lvl != LV_OFF);
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fw_clear,
    input logic [NCH-1:0] pwm_in,
    input logic [NCH-1:0] pwm_out,
    input logic           stage_en,
    input logic [2:0]     level_o,
    input logic           short_flag,
    input logic           oc_flag
);
    // R6
    off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 3'd4) |-> (pwm_out == '0 && !stage_en));

    // R6
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_o) == 3'd4 && !$past(fw_clear)) |-> (level_o == 3'd4));

    // R4
    no_extra_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~pwm_in) == '0);

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_flag && oc_flag));

    // R9
    flag_means_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_flag || oc_flag) |-> (level_o == 3'd4));

    // R7
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fw_clear) |-> ({1'b0, level_o} + 4'd1 >= {1'b0, $past(level_o)}));

    // R10
    clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fw_clear) |-> (level_o == 3'd0 && !short_flag && !oc_flag));
endmodule

bind ocp_guard ocp_guard_chk #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .fw_clear(fw_clear), .pwm_in(pwm_in),
    .pwm_out(pwm_out), .stage_en(stage_en), .level_o(level_o),
    .short_flag(short_flag), .oc_flag(oc_flag)
);

// File: tb/ocp_guard_tb.sv
module ocp_guard_tb_top;
    localparam int NCH = 2;
    localparam int CNT_W = 4;
    localparam int RUN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_strobe = 1'b0;
    logic             fw_clear = 1'b0;
    logic [NCH-1:0]   oc_raw = '0;
    logic [NCH-1:0]   pwm_in = '1;
    logic [CNT_W-1:0] thr_clip = 4'd2;
    logic [CNT_W-1:0] thr_atten = 4'd3;
    logic [CNT_W-1:0] thr_off = 4'd5;
    logic [CNT_W-1:0] quiet_frames = 4'd2;
    logic [RUN_W-1:0] sc_limit = 8'd10;
    logic [NCH-1:0]   pwm_out;
    logic             drive_cut, atten_on, stage_en, short_flag, oc_flag;
    logic [2:0]       level_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ocp_guard #(.NCH(NCH), .CNT_W(CNT_W), .RUN_W(RUN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .fw_clear(fw_clear),
        .oc_raw(oc_raw), .pwm_in(pwm_in), .thr_clip(thr_clip), .thr_atten(thr_atten),
        .thr_off(thr_off), .quiet_frames(quiet_frames), .sc_limit(sc_limit),
        .pwm_out(pwm_out), .drive_cut(drive_cut), .atten_on(atten_on),
        .stage_en(stage_en), .level_o(level_o), .short_flag(short_flag), .oc_flag(oc_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_frame();
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic body(input int len, input logic [NCH-1:0] m);
        for (int i = 0; i < 16; i++) begin
            oc_raw = (i < len) ? m : '0;
            @(negedge clk);
        end
        oc_raw = '0;
    endtask

    task automatic pulse_clear();
        fw_clear = 1'b1;
        @(negedge clk);
        fw_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 level", level_o, 0);
        chk("R11 stage_en", stage_en, 1);
        chk("R11 flags", {short_flag, oc_flag, drive_cut}, 0);
        chk("R11 pwm_out", pwm_out, 3);
    endtask

    task automatic t_cut();
        oc_raw = 2'b01;
        @(negedge clk);
        chk("R1 after edge 1", drive_cut, 0);
        @(negedge clk);
        chk("R1 after edge 2", drive_cut, 0);
        @(negedge clk);
        chk("R1 after edge 3", drive_cut, 1);
        oc_raw = '0;
        for (int i = 0; i < 13; i++) @(negedge clk);
        chk("R2 level cut", level_o, 1);
        chk("R2 no clip at cut", pwm_out, 3);
    endtask

    task automatic t_escalate();
        start_frame();
        chk("R3 one hit frame", level_o, 1);
        body(3, 2'b01);
        start_frame();
        chk("R3 clip level", level_o, 2);
        chk("R5 no atten at clip", atten_on, 0);
        body(4, 2'b01);
        chk("R4 channel 0 clipped", pwm_out, 2'b10);
        start_frame();
        chk("R3 atten level", level_o, 3);
        chk("R5 atten on", atten_on, 1);
        chk("R4 clip released", pwm_out, 3);
        body(3, 2'b10);
        start_frame();
        chk("R3 fourth hit", level_o, 3);
        body(3, 2'b10);
        start_frame();
        chk("R3 off level", level_o, 4);
        chk("R6 stage off", stage_en, 0);
        chk("R6 pwm blocked", pwm_out, 0);
        chk("R9 oc flag", {short_flag, oc_flag}, 1);
    endtask

    task automatic t_sticky();
        for (int k = 0; k < 5; k++) begin
            body(0, '0);
            start_frame();
        end
        chk("R6 off held", level_o, 4);
        pulse_clear();
        chk("R10 level cleared", level_o, 0);
        chk("R10 flags cleared", {short_flag, oc_flag}, 0);
        chk("R10 stage on", stage_en, 1);
    endtask

    task automatic t_deescalate();
        body(3, 2'b01);
        start_frame();
        body(3, 2'b01);
        start_frame();
        body(3, 2'b01);
        start_frame();
        chk("R7 start at atten", level_o, 3);
        body(0, '0);
        start_frame();
        chk("R7 first quiet frame holds", level_o, 3);
        body(0, '0);
        start_frame();
        chk("R7 step to clip", level_o, 2);
        body(0, '0);
        start_frame();
        body(0, '0);
        start_frame();
        chk("R7 step to cut", level_o, 1);
        body(0, '0);
        start_frame();
        body(0, '0);
        start_frame();
        chk("R7 step to idle", level_o, 0);
    endtask

    task automatic t_short();
        body(10, 2'b10);
        chk("R8 run at limit", short_flag, 0);
        chk("R8 level only cut", level_o, 1);
        start_frame();
        body(11, 2'b10);
        chk("R8 run past limit", level_o, 4);
        chk("R9 short flag", {short_flag, oc_flag}, 2);
        chk("R8 stage off", stage_en, 0);
        pulse_clear();
    endtask

    task automatic t_clear_vs_strobe();
        body(3, 2'b01);
        chk("R2 cut before clear", level_o, 1);
        fw_clear = 1'b1;
        frame_strobe = 1'b1;
        @(negedge clk);
        fw_clear = 1'b0;
        frame_strobe = 1'b0;
        @(negedge clk);
        chk("R10 clear beats strobe", level_o, 0);
        body(3, 2'b01);
        start_frame();
        chk("R10 hit not counted", level_o, 1);
        body(3, 2'b01);
        start_frame();
        chk("R10 count restarted", level_o, 2);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cut();
        t_escalate();
        t_sticky();
        t_deescalate();
        t_short();
        t_clear_vs_strobe();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule